// File: doc/BRIEF.md
# Interpacket Gap Deferral Timer

This block tells a CSMA/CD transmitter when the shared medium has been quiet for long enough to begin a frame. It watches a carrier-sense input that is already synchronised to its clock. It counts idle time in bit-time units, using a one-cycle `bitTick` enable that the surrounding logic produces once per bit period. The timer starts each time carrier falls. At 10 Mb/s the full gap is 9.6 microseconds, which is 96 bit times.

The gap has two phases. In the first phase, carrier that returns sends the timer back to the busy state, and a fresh gap begins when that carrier ends. In the second phase, carrier is disregarded and the count runs to completion. Two stations that start slightly apart therefore both transmit, and backoff settles the contention; an earlier start gives no advantage. When the gap completes, `txPermit` rises. It stays high while the medium is idle and clears once carrier is seen again.

Backoff, jam and frame sequencing belong to the transmitter that consumes `txPermit`. After reset the block behaves as though carrier has just ended, so a full gap must run before the first permit.

Top module: `ipg_defer_timer`

## Requirements
- R1: While reset is low, and at the first cycle after it is released, gapPhase is 2'b01 (first phase) and txPermit is 0. txPermit first rises only after GAP_TICKS bit ticks have occurred following the release.
- R2: Carrier sampled high in any phase other than the second phase gives gapPhase 2'b00 (busy) and txPermit 0 on the following cycle. Both stay that way for as long as carrier remains high.
- R3: Carrier sampled low in the busy phase gives gapPhase 2'b01 on the next cycle, with the tick count cleared. A bitTick on that same edge is not counted.
- R4: The first phase lasts exactly FIRST_TICKS counted ticks. The tick that completes it moves gapPhase to 2'b10 (second phase).
- R5: Carrier sampled high in the first phase moves gapPhase to 2'b00 on the next cycle, even when a bitTick falls on the same edge. A full gap is then timed again from the next falling edge of carrier.
- R6: In the second phase, carrier is ignored. gapPhase goes only to 2'b10 or 2'b11, and the gap ends after the same number of ticks as it would with no carrier.
- R7: txPermit rises, and gapPhase becomes 2'b11 (open), on the cycle after the GAP_TICKS-th tick counted since the gap began. It never rises earlier.
- R8: Once the gap is open, txPermit stays at 1 for every cycle in which carrier stays low. It drops to 0, with gapPhase 2'b00, on the cycle after carrier is sampled high.
- R9: Cycles without bitTick do not advance the timer. With a tick once every D cycles, the open phase is reached GAP_TICKS*D cycles after timing starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| carrierSense | input | 1 | Synchronised carrier-present indication from the medium |
| bitTick | input | 1 | One-cycle enable, once per bit time |
| txPermit | output | 1 | High when the transmitter may start a frame |
| gapPhase | output | 2 | 00 busy, 01 first (restartable) phase, 10 second (locked) phase, 11 open |

## Verification
A counter that is off by one in this block shows at the ports as `txPermit` rising a tick early or late. On a dense tick stream the error appears within the gap length in cycles; with sparse ticks the delay is multiplied by the tick spacing. A wrong phase decision appears as soon as carrier arrives. Carrier in the second phase that is wrongly honoured drops `gapPhase` to busy on the next cycle. Carrier in the first phase that is wrongly ignored leaves `gapPhase` at first or second. The bench therefore compares `gapPhase` and `txPermit` on every cycle of every gap against a count of ticks computed arithmetically. It sweeps carrier arrival over every tick position of both phases for several tick spacings.

// File: rtl/ipg_defer_pkg.sv
package ipg_defer_pkg;

  typedef enum logic [1:0] {
    PH_BUSY   = 2'b00,
    PH_FIRST  = 2'b01,
    PH_SECOND = 2'b10,
    PH_OPEN   = 2'b11
  } gapPhase_e;

  typedef struct packed {
    logic clr;
    logic inc;
  } cntStrobe_t;

endpackage

// File: rtl/ipg_defer_count.sv
module ipg_defer_count #(
  parameter int FIRST_TICKS = 64,
  parameter int GAP_TICKS   = 96,
  parameter int CNT_W       = $clog2(GAP_TICKS + 1)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ipg_defer_pkg::cntStrobe_t strobe,
  output logic [CNT_W-1:0]          gapCount,
  output logic                      firstLast,
  output logic                      gapLast
);

  localparam logic [CNT_W-1:0] FIRST_END = CNT_W'(FIRST_TICKS - 1);
  localparam logic [CNT_W-1:0] GAP_END   = CNT_W'(GAP_TICKS - 1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gapCount <= '0;
    end else if (strobe.clr) begin
      gapCount <= '0;
    end else if (strobe.inc) begin
      gapCount <= gapCount + 1'b1;
    end
  end

  assign firstLast = (gapCount == FIRST_END);
  assign gapLast   = (gapCount == GAP_END);

endmodule

// File: rtl/ipg_defer_ctrl.sv
module ipg_defer_ctrl
  import ipg_defer_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       carrierSense,
  input  logic       bitTick,
  input  logic       firstLast,
  input  logic       gapLast,
  output cntStrobe_t strobe,
  output gapPhase_e  phaseState
);

  gapPhase_e phaseNext;

  always_comb begin
    phaseNext = phaseState;
    strobe    = '0;
    unique case (phaseState)
      PH_BUSY: begin
        strobe.clr = 1'b1;
        if (!carrierSense) phaseNext = PH_FIRST;
      end
      PH_FIRST: begin
        if (carrierSense) begin
          phaseNext = PH_BUSY;
        end else if (bitTick) begin
          strobe.inc = 1'b1;
          if (firstLast) phaseNext = PH_SECOND;
        end
      end
      PH_SECOND: begin
        if (bitTick) begin
          strobe.inc = 1'b1;
          if (gapLast) phaseNext = PH_OPEN;
        end
      end
      PH_OPEN: begin
        if (carrierSense) phaseNext = PH_BUSY;
      end
      default: phaseNext = PH_FIRST;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phaseState <= PH_FIRST;
    else       phaseState <= phaseNext;
  end

endmodule

// File: rtl/ipg_defer_timer.sv
module ipg_defer_timer #(
  parameter int FIRST_TICKS = 64,
  parameter int GAP_TICKS   = 96
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       carrierSense,
  input  logic       bitTick,
  output logic       txPermit,
  output logic [1:0] gapPhase
);
  import ipg_defer_pkg::*;

  localparam int CNT_W = $clog2(GAP_TICKS + 1);

  generate
    if (FIRST_TICKS < 1 || FIRST_TICKS >= GAP_TICKS) begin : g_badCfg
      $error("FIRST_TICKS must be at least 1 and below GAP_TICKS");
    end
  endgenerate

  cntStrobe_t       strobe;
  gapPhase_e        phaseState;
  logic [CNT_W-1:0] gapCount;
  logic             firstLast;
  logic             gapLast;

  ipg_defer_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .carrierSense(carrierSense),
    .bitTick     (bitTick),
    .firstLast   (firstLast),
    .gapLast     (gapLast),
    .strobe      (strobe),
    .phaseState  (phaseState)
  );

  ipg_defer_count #(
    .FIRST_TICKS(FIRST_TICKS),
    .GAP_TICKS  (GAP_TICKS),
    .CNT_W      (CNT_W)
  ) u_count (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .gapCount (gapCount),
    .firstLast(firstLast),
    .gapLast  (gapLast)
  );

  assign gapPhase = phaseState;
  assign txPermit = (phaseState == PH_OPEN);

endmodule

// File: rtl/ipg_defer_checker.sv
module ipg_defer_checker #(
  parameter int CNT_W = 7
) (
  input logic             clk,
  input logic             rstN,
  input logic             carrierSense,
  input logic             bitTick,
  input logic             txPermit,
  input logic [1:0]       gapPhase,
  input logic [CNT_W-1:0] gapCount
);

  p_carrier_busy_r2: assert property (@(posedge clk) disable iff (!rstN)
    (carrierSense && gapPhase != 2'b10) |=> (gapPhase == 2'b00 && !txPermit));

  p_fall_clears_r3: assert property (@(posedge clk) disable iff (!rstN)
    (gapPhase == 2'b00 && !carrierSense) |=> (gapPhase == 2'b01 && gapCount == '0));

  p_second_locked_r6: assert property (@(posedge clk) disable iff (!rstN)
    (gapPhase == 2'b10) |=> (gapPhase == 2'b10 || gapPhase == 2'b11));

  p_open_entry_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txPermit) |-> ($past(gapPhase) == 2'b10 && $past(bitTick)));

  p_open_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (txPermit && !carrierSense) |=> txPermit);

  p_no_tick_stall_r9: assert property (@(posedge clk) disable iff (!rstN)
    (gapPhase == 2'b01 && !bitTick && !carrierSense) |=> (gapPhase == 2'b01 && $stable(gapCount)));

endmodule

bind ipg_defer_timer ipg_defer_checker #(.CNT_W(CNT_W)) u_ipgChecker (
  .clk         (clk),
  .rstN        (rstN),
  .carrierSense(carrierSense),
  .bitTick     (bitTick),
  .txPermit    (txPermit),
  .gapPhase    (gapPhase),
  .gapCount    (gapCount)
);

// File: tb/ipg_defer_timer_bench.sv
module ipg_defer_timer_bench;

  localparam int FIRST = 4;
  localparam int GAP   = 6;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       carrierSense = 1'b0;
  logic       bitTick = 1'b0;
  logic       txPermit;
  logic [1:0] gapPhase;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;

  always #2 clk = ~clk;

  ipg_defer_timer #(.FIRST_TICKS(FIRST), .GAP_TICKS(GAP)) u_ipg_defer_timer (
    .clk         (clk),
    .rstN        (rstN),
    .carrierSense(carrierSense),
    .bitTick     (bitTick),
    .txPermit    (txPermit),
    .gapPhase    (gapPhase)
  );

  task automatic chk(input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d exp %0d", what, got, exp);
    end
  endtask

  task automatic chkBoth(input string tag, input int expPh, input int expPermit);
    chk({tag, " gapPhase"}, int'(gapPhase), expPh);
    chk({tag, " txPermit"}, int'(txPermit), expPermit);
  endtask

  // Iteration i samples state after edges e0..e(i-1); ticks fall on edges e(k*d).
  task automatic runLoop(input int d, input int restartAt, input int pOff,
                         input int pLen, input string tag);
    int pStart;
    pStart = FIRST * d + 1 + pOff;
    for (int i = 1; i <= GAP * d + 1; i++) begin
      int ticks;
      int expPh;
      string region;
      @(negedge clk);
      ticks  = (i - 1) / d;
      expPh  = (ticks < FIRST) ? 1 : (ticks < GAP) ? 2 : 3;
      region = (ticks >= GAP) ? "R7" : (ticks >= FIRST) ? ((pOff >= 0) ? "R6" : "R4")
             : ((d > 1) ? "R9" : "R4");
      chkBoth({tag, "/", region}, expPh, (ticks >= GAP) ? 1 : 0);
      if (i == restartAt) begin
        carrierSense = 1'b1;
        bitTick      = (i % d == 0);
        return;
      end
      carrierSense = (pOff >= 0) && (i >= pStart) && (i < pStart + pLen);
      bitTick      = (i % d == 0);
    end
  endtask

  task automatic gapRun(input int d, input int restartAt, input int pOff,
                        input int pLen, input string tag);
    @(negedge clk);
    carrierSense = 1'b0;
    bitTick      = 1'b0;
    runLoop(d, restartAt, pOff, pLen, tag);
  endtask

  task automatic goBusy(input string tag);
    carrierSense = 1'b1;
    bitTick      = 1'b1;
    @(negedge clk);
    chkBoth(tag, 0, 0);
  endtask

  initial begin
    repeat (3) begin
      @(negedge clk);
      chkBoth("R1 in reset", 1, 0);
    end
    rstN = 1'b1;
    runLoop(1, 0, -1, 0, "R1");

    goBusy("R8 carrier after open");
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chkBoth("R2 carrier held", 0, 0);
    end

    for (int d = 1; d <= 3; d++) begin
      gapRun(d, 0, -1, 0, "R3");
      for (int k = 0; k < 5; k++) begin
        bitTick = 1'b1;
        @(negedge clk);
        chkBoth("R8 idle open", 3, 1);
      end
      goBusy("R8 drop");
      @(negedge clk);
      chkBoth("R2 busy", 0, 0);
    end

    for (int d = 1; d <= 2; d++) begin
      for (int r = 1; r <= FIRST * d; r++) begin
        gapRun(d, r, -1, 0, "R5 pre");
        bitTick = 1'b1;
        @(negedge clk);
        chkBoth("R5 restart", 0, 0);
        @(negedge clk);
        chkBoth("R2 restart hold", 0, 0);
        gapRun(d, 0, -1, 0, "R5 regap");
        goBusy("R8 after regap");
      end
    end

    for (int d = 1; d <= 2; d++) begin
      for (int off = 0; off < (GAP - FIRST) * d; off++) begin
        gapRun(d, 0, off, 1, "R6 pulse");
        goBusy("R8 after pulse");
      end
      gapRun(d, 0, 0, (GAP - FIRST) * d, "R6 long");
      goBusy("R8 after long");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired before the sequence finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule